// File: doc/BRIEF.md
# Multi-Address I2C Register Target

This block is an I2C target that holds a small file of 8-bit registers and answers on the bus to three 7-bit device addresses at once. One of them is a private address that can both read and write. The other two are shared group addresses. Several devices on one bus can be given the same group address, so a master can update all of them with one write. A read on a group address is refused: the target leaves the acknowledge bit high and drives nothing else.

The three addresses are ordinary registers inside the register file, so the master can move a device to a new address with a normal write. After reset all three hold the same default value (parameter `DEFAULT_ADDR`, 0x48 by default). A device that has just come out of reset therefore answers reads and writes at that value. A write transaction carries the device address, then a pointer byte, then any number of data bytes, and the pointer steps forward by one after each byte. A read uses the current pointer: the master usually sets it with a short write, then sends a repeated START and the read address. The block samples SCL and SDA into its own clock domain and detects START, STOP and clock edges there. It never stretches the clock.

Top module: `i2c_multi_addr_target`

## Requirements
- R1: After reset the private, group-1 and group-2 address registers all read 0x48 (`DEFAULT_ADDR`), every other register reads 0x00, and SDA is released (`sda_oe_o` = 0).
- R2: An address byte whose upper 7 bits equal the private address is acknowledged with either R/W bit (bit 0, 1 = read). In a write, the first byte after the address is loaded into the register pointer (its low `$clog2(NUM_REGS)` bits are kept). Each following byte is written to the register at the pointer and acknowledged, and the pointer then increments.
- R3: An address byte that matches only a group address is acknowledged when its R/W bit is 0, and the data written through it lands in the register file. When its R/W bit is 1 the byte is not acknowledged (SDA stays high in the acknowledge slot).
- R4: A read sends the register at the current pointer MSB first and then increments the pointer. A master ACK fetches the next register. A master NACK ends the read, and the target then releases SDA.
- R5: The private address is held in register 0x1B, group 1 in 0x1A and group 2 in 0x19. The address is taken from bits [6:0] of the written byte, and bit 7 of these registers always reads 0.
- R6: After an address register is rewritten, the device no longer acknowledges the old value for that role.
- R7: When the private address and a group address hold the same value, the private rules apply, so a read at that value is acknowledged.
- R8: A new address value takes effect at the next START or repeated START. Bytes that follow in the transaction that wrote it are still acknowledged.
- R9: An address byte that matches none of the three addresses is not acknowledged, and the target leaves SDA released until the next START.
- R10: A STOP at any point, including partway through a data byte, ends the transaction, and the partial byte is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, the target pulls SDA low |

## Verification
The bench uses four kinds of transaction. Reads and writes on the private address show pointer loading, auto-increment and data return. Writes and refused reads on each group address show that the R/W bit alone decides whether a group match is acknowledged. Each address register is rewritten in turn, and the bench then probes both the old and the new value, so the match is shown to follow the registers and not a fixed constant. It also sends a repeated START straight after an address change, which shows that the new value applies from the next START. Setting a group address equal to the private address tests precedence. An unknown address and a STOP in the middle of a byte show that nothing is acknowledged or written outside a valid transaction.

// File: rtl/i2c_mat_pkg.sv
package i2c_mat_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;
  logic scl_s, sda_s;

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_prev;
  assign scl_fall_o = ~scl_s & scl_prev;
  assign start_o    = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_o     = scl_s & scl_prev & ~sda_prev & sda_s;

  p_start_stop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o));
  p_edge_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_rise_o && scl_fall_o));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int          DEV_W        = 7,
  parameter logic [6:0]  DEFAULT_ADDR = 7'h48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DEV_W-1:0] ind_live_i,
  input  logic [DEV_W-1:0] g1_live_i,
  input  logic [DEV_W-1:0] g2_live_i,
  input  logic [DEV_W:0]   addr_byte_i,
  output logic             accept_o,
  output logic             grp_read_o
);
  logic [DEV_W-1:0] ind_q, g1_q, g2_q;
  logic [DEV_W-1:0] dev;
  logic             rd, ind_hit, grp_hit;

  // snapshot of the address registers, refreshed only at START
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ind_q <= DEFAULT_ADDR;
      g1_q  <= DEFAULT_ADDR;
      g2_q  <= DEFAULT_ADDR;
    end else if (start_i) begin
      ind_q <= ind_live_i;
      g1_q  <= g1_live_i;
      g2_q  <= g2_live_i;
    end
  end

  assign dev        = addr_byte_i[DEV_W:1];
  assign rd         = addr_byte_i[0];
  assign ind_hit    = (dev == ind_q);
  assign grp_hit    = (dev == g1_q) || (dev == g2_q);
  assign accept_o   = ind_hit || (grp_hit && !rd);
  assign grp_read_o = !ind_hit && grp_hit && rd;

  p_snapshot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(ind_q) && $stable(g1_q) && $stable(g2_q)));
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
  parameter int         NUM_REGS     = 32,
  parameter int         IND_IDX      = 27,
  parameter int         G1_IDX       = 26,
  parameter int         G2_IDX       = 25,
  parameter logic [6:0] DEFAULT_ADDR = 7'h48,
  localparam int        IDX_W        = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rdata_o,
  output logic [6:0]       ind_addr_o,
  output logic [6:0]       g1_addr_o,
  output logic [6:0]       g2_addr_o
);
  logic [NUM_REGS-1:0][7:0] rd_vec;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    localparam bit IS_ADDR = (gi == IND_IDX) || (gi == G1_IDX) || (gi == G2_IDX);
    logic sel;
    assign sel = we_i && (wr_idx_i == IDX_W'(gi));
    if (IS_ADDR) begin : g_addr
      logic [6:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= DEFAULT_ADDR;
        else if (sel) q <= wdata_i[6:0];
      end
      assign rd_vec[gi] = {1'b0, q};
    end else begin : g_data
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (sel) q <= wdata_i;
      end
      assign rd_vec[gi] = q;
    end
  end

  assign rdata_o    = rd_vec[rd_idx_i];
  assign ind_addr_o = rd_vec[IND_IDX][6:0];
  assign g1_addr_o  = rd_vec[G1_IDX][6:0];
  assign g2_addr_o  = rd_vec[G2_IDX][6:0];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> rd_vec[$past(wr_idx_i)][6:0] == $past(wdata_i[6:0]));
  p_addr_msb_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vec[IND_IDX][7] && !rd_vec[G1_IDX][7] && !rd_vec[G2_IDX][7]);
endmodule

// File: rtl/i2c_multi_addr_target.sv
module i2c_multi_addr_target
  import i2c_mat_pkg::*;
#(
  parameter int         NUM_REGS     = 32,
  parameter logic [6:0] DEFAULT_ADDR = 7'h48,
  parameter int         IND_IDX      = 27,
  parameter int         G1_IDX       = 26,
  parameter int         G2_IDX       = 25,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int PTR_W = $clog2(NUM_REGS);

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic accept, grp_read;
  logic [6:0] ind_live, g1_live, g2_live;
  logic [7:0] rdata;

  tgt_state_e      state_q, state_n;
  logic [3:0]      cnt_q, cnt_n;
  logic [7:0]      sh_q, sh_n;
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic            rw_q, rw_n, drv_q, drv_n, mack_q, mack_n;
  logic            we;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2c_addr_match #(.DEV_W(DEV_W), .DEFAULT_ADDR(DEFAULT_ADDR)) u_match (
    .clk(clk), .rst_n(rst_n), .start_i(start_ev),
    .ind_live_i(ind_live), .g1_live_i(g1_live), .g2_live_i(g2_live),
    .addr_byte_i(sh_q), .accept_o(accept), .grp_read_o(grp_read)
  );

  i2c_regbank #(
    .NUM_REGS(NUM_REGS), .IND_IDX(IND_IDX), .G1_IDX(G1_IDX), .G2_IDX(G2_IDX),
    .DEFAULT_ADDR(DEFAULT_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(we), .wr_idx_i(ptr_q), .wdata_i(sh_q),
    .rd_idx_i(ptr_q), .rdata_o(rdata),
    .ind_addr_o(ind_live), .g1_addr_o(g1_live), .g2_addr_o(g2_live)
  );

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    ptr_n   = ptr_q;
    rw_n    = rw_q;
    drv_n   = drv_q;
    mack_n  = mack_q;
    we      = 1'b0;
    if (stop_ev) begin
      state_n = ST_IDLE;
      drv_n   = 1'b0;
    end else if (start_ev) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      drv_n   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            drv_n = 1'b1;
            if (state_q == ST_ADDR) begin
              if (accept) begin
                state_n = ST_ADDR_ACK;
                rw_n    = sh_q[0];
              end else begin
                state_n = ST_IDLE;
                drv_n   = 1'b0;
              end
            end else if (state_q == ST_PTR) begin
              ptr_n   = sh_q[PTR_W-1:0];
              state_n = ST_PTR_ACK;
            end else begin
              we      = 1'b1;
              ptr_n   = ptr_q + 1'b1;
              state_n = ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (state_q == ST_ADDR_ACK && rw_q) begin
              state_n = ST_RDATA;
              sh_n    = rdata;
              ptr_n   = ptr_q + 1'b1;
              drv_n   = ~rdata[7];
            end else begin
              state_n = (state_q == ST_ADDR_ACK) ? ST_PTR : ST_WDATA;
              drv_n   = 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              state_n = ST_RACK;
              drv_n   = 1'b0;
            end else begin
              sh_n  = {sh_q[6:0], 1'b0};
              cnt_n = cnt_q + 4'd1;
              drv_n = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_n = ST_RDATA;
              cnt_n   = '0;
              sh_n    = rdata;
              ptr_n   = ptr_q + 1'b1;
              drv_n   = ~rdata[7];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      drv_q   <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      ptr_q   <= ptr_n;
      rw_q    <= rw_n;
      drv_q   <= drv_n;
      mack_q  <= mack_n;
    end
  end

  assign sda_oe_o = drv_q;

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !sda_oe_o);
  p_group_read_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && scl_fall && cnt_q == 4'd8 && grp_read && !start_ev && !stop_ev)
      |=> (!sda_oe_o && state_q == ST_IDLE));
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state_q == ST_IDLE && !sda_oe_o));
endmodule

// File: tb/i2c_multi_addr_target_tb.sv
module i2c_multi_addr_target_tb_top;
  localparam time Q = 40ns;

  logic clk, rst_n, scl_m, sda_m;
  wire  sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  i2c_multi_addr_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  typedef struct { string tag; logic [7:0] val; } exp_t;
  exp_t exp_q[$];
  logic [7:0] obs_val;
  event obs_ev;
  int checks = 0, failures = 0;
  bit done = 0;

  // monitor: pops the oldest expectation each time a result is observed
  initial begin
    forever begin
      @(obs_ev);
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected: actual=%02h expected=<none>", obs_val);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        if (obs_val !== it.val) begin
          failures++;
          $display("FAIL %s: actual=%02h expected=%02h", it.tag, obs_val, it.val);
        end
      end
    end
  end

  task automatic expect_item(input string tg, input logic [7:0] v);
    exp_t it;
    it.tag = tg; it.val = v;
    exp_q.push_back(it);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_val = v;
    -> obs_ev;
    #1ns;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; #Q; scl_m = 1'b1; #Q; s = sda_bus; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack_bit);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(d[i], s);
    bit_io(1'b1, ack_bit);
  endtask

  // acknowledge slot observed: 0 = ACK, 1 = NACK
  task automatic tx(input logic [7:0] d, input logic exp_nack, input string tg);
    logic a;
    expect_item(tg, {7'd0, exp_nack});
    send_byte(d, a);
    observe({7'd0, a});
  endtask

  task automatic rx(input logic [7:0] e, input logic last, input string tg);
    logic [7:0] v;
    logic s;
    expect_item(tg, e);
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); v[i] = s; end
    observe(v);
    bit_io(last, s);
  endtask

  task automatic t_write(input logic [6:0] a, input logic [7:0] p, input int n,
                         input logic [7:0] d0, input logic [7:0] d1, input string tg);
    bus_start();
    tx({a, 1'b0}, 1'b0, tg);
    tx(p, 1'b0, tg);
    tx(d0, 1'b0, tg);
    if (n > 1) tx(d1, 1'b0, tg);
    bus_stop();
  endtask

  task automatic t_read(input logic [6:0] a, input logic [7:0] p, input int n,
                        input logic [7:0] e0, input logic [7:0] e1, input logic [7:0] e2,
                        input string tg);
    bus_start();
    tx({a, 1'b0}, 1'b0, tg);
    tx(p, 1'b0, tg);
    bus_start();
    tx({a, 1'b1}, 1'b0, tg);
    rx(e0, n == 1, tg);
    if (n > 1) rx(e1, n == 2, tg);
    if (n > 2) rx(e2, 1'b1, tg);
    bus_stop();
  endtask

  task automatic t_probe(input logic [6:0] a, input logic rw, input logic exp_nack,
                         input string tg);
    bus_start();
    tx({a, rw}, exp_nack, tg);
    bus_stop();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    repeat (10) @(posedge clk);
    #1ns rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1ns;
    checks++;
    if (sda_oe !== 1'b0) begin
      failures++;
      $display("FAIL R1: actual=%0b expected=0 (sda_oe after reset)", sda_oe);
    end

    // R1: defaults in all three address registers and a data register
    t_read(7'h48, 8'h19, 3, 8'h48, 8'h48, 8'h48, "R1");
    t_read(7'h48, 8'h00, 1, 8'h00, 8'h00, 8'h00, "R1");

    // R2 / R4: write two bytes, read them back with auto-increment
    t_write(7'h48, 8'h02, 2, 8'hA5, 8'h3C, "R2");
    t_read(7'h48, 8'h02, 2, 8'hA5, 8'h3C, 8'h00, "R4");

    // R5 / R8: private address set to 0xA1 -> 0x21; next byte still ACKed
    t_write(7'h48, 8'h1B, 2, 8'hA1, 8'h77, "R8");
    t_read(7'h21, 8'h1B, 2, 8'h21, 8'h77, 8'h00, "R5");

    // R3: 0x48 is now group-only: read refused, write accepted
    t_probe(7'h48, 1'b1, 1'b1, "R3");
    t_write(7'h48, 8'h05, 1, 8'h5A, 8'h00, "R3");
    t_read(7'h21, 8'h05, 1, 8'h5A, 8'h00, 8'h00, "R3");

    // R5: group 2 at 0x19, group 1 at 0x1A
    t_write(7'h21, 8'h19, 2, 8'h31, 8'h30, "R5");
    t_read(7'h21, 8'h19, 3, 8'h31, 8'h30, 8'h21, "R5");

    // R6: old default no longer answered
    t_probe(7'h48, 1'b0, 1'b1, "R6");

    // R3: writes through each new group address, read refused on one
    t_write(7'h30, 8'h06, 1, 8'h66, 8'h00, "R3");
    t_write(7'h31, 8'h07, 1, 8'h99, 8'h00, "R3");
    t_read(7'h21, 8'h06, 2, 8'h66, 8'h99, 8'h00, "R3");
    t_probe(7'h30, 1'b1, 1'b1, "R3");

    // R8: new private address answered straight after a repeated START
    bus_start();
    tx({7'h21, 1'b0}, 1'b0, "R8");
    tx(8'h1B, 1'b0, "R8");
    tx(8'h22, 1'b0, "R8");
    bus_start();
    tx({7'h22, 1'b0}, 1'b0, "R8");
    tx(8'h1B, 1'b0, "R8");
    bus_start();
    tx({7'h22, 1'b1}, 1'b0, "R8");
    rx(8'h22, 1'b1, "R8");
    bus_stop();
    t_probe(7'h21, 1'b1, 1'b1, "R6");

    // R7: group 2 equal to the private address, read allowed
    t_write(7'h22, 8'h19, 1, 8'h22, 8'h00, "R7");
    t_read(7'h22, 8'h19, 1, 8'h22, 8'h00, 8'h00, "R7");

    // R9: unknown address, either direction
    t_probe(7'h55, 1'b0, 1'b1, "R9");
    t_probe(7'h55, 1'b1, 1'b1, "R9");

    // R10: STOP after three data bits leaves register 8 untouched
    bus_start();
    tx({7'h22, 1'b0}, 1'b0, "R10");
    tx(8'h08, 1'b0, "R10");
    begin
      logic s;
      bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s);
    end
    bus_stop();
    t_read(7'h22, 8'h08, 1, 8'h00, 8'h00, 8'h00, "R10");

    #100ns;
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending items", exp_q.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule